// File: doc/BRIEF.md
# Masked byte insert compare unit

This unit performs one of three byte-wise operations between a 64-bit general register and a byte-addressed memory, steered by a 4-bit lane mask. It can load selected memory bytes into the register, compare selected register bytes against memory, or write selected register bytes out to memory. Each operation works on a 32-bit field of the register: normally bits 31:0, or bits 63:32 when the high-half option is set.

The unit is started with a single-cycle start pulse that carries the opcode, mask, register value and start address. It walks the mask from the most significant lane down and issues one memory byte request for each selected lane only. It then reports the updated register, a 2-bit condition code and a one-cycle done pulse. Memory is reached through a plain request/valid byte port. Address translation and faults are handled elsewhere.

Top module: `mbic_unit`

## Requirements
- R1: Mask bit i selects byte lane i of the 32-bit field, so bit 3 is the most significant byte and bit 0 the least. Selected lanes are processed from lane 3 down to lane 0.
- R2: The k-th selected lane (k = 0, 1, ...) uses memory address start + k. Unselected lanes neither advance the address nor cause a memory request.
- R3: Insert (opcode 0) replaces each selected register byte with its memory byte. Every other register bit keeps its value.
- R4: The insert code is 1 when the first inserted byte has bit 7 set. It is 0 when the mask is zero or every inserted byte is zero. Otherwise it is 2.
- R5: Compare (opcode 1) compares register bytes with memory bytes as unsigned values. The first unequal byte ends the operation, with code 1 when the register byte is lower and 2 when it is higher, and no later lane is requested. When every selected byte matches, or the mask is zero, the code is 0. The register is not changed.
- R6: Store (opcode 2) writes the selected register bytes to consecutive addresses, most significant lane first. The register is left unchanged and the code is 0.
- R7: With the high-half option set, the lanes are register bits 63:32, with lane 3 starting at bit 56 and each lane 8 bits lower. Bits 31:0 are then untouched.
- R8: Each selected lane holds one request, with constant address, write enable and write data, until valid is returned. The next request, or done, follows in the next cycle. A zero mask gives done in the cycle after start. Done lasts exactly one cycle.
- R9: A start pulse while an operation is in progress has no effect. A start with opcode 3 is ignored: no request and no done.
- R10: After reset, done and the memory request are low, the register output is zero and the code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| op | input | 2 | 0 insert, 1 compare, 2 store, 3 reserved |
| high_half | input | 1 | Operate on bits 63:32 instead of 31:0 |
| mask | input | 4 | Lane select mask |
| reg_in | input | 64 | Register value at start |
| addr_in | input | 16 | Start byte address |
| reg_out | output | 64 | Working/updated register value |
| cc | output | 2 | Condition code |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_valid |
| mem_valid | input | 1 | Request completed |

## Verification
The bench builds the unit with its default parameters: four lanes, a 64-bit register, the high-half variant enabled and 16-bit addresses. With only four lanes, every one of the 16 masks can be swept for every opcode and both halves. This reaches every sparse mask pattern and every early-exit position of compare. Register and memory patterns include all-zero bytes, sign-bit bytes, fully matching fields and fields with one byte higher or lower. Together these reach each condition-code branch and the latency of 2 cycles per selected lane against a one-cycle memory model.

// File: rtl/mbic_pkg.sv
package mbic_pkg;
   typedef enum logic [1:0] {
      OP_INSERT  = 2'd0,
      OP_COMPARE = 2'd1,
      OP_STORE   = 2'd2,
      OP_RSVD    = 2'd3
   } mbic_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_DONE = 2'd2
   } mbic_state_e;

   localparam logic [1:0] CC_ZERO = 2'd0;
   localparam logic [1:0] CC_ONE  = 2'd1;
   localparam logic [1:0] CC_TWO  = 2'd2;
endpackage

// File: rtl/mbic_lane_scan.sv
module mbic_lane_scan #(
   parameter int LANES = 4,
   localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0] pend,
   output logic [LW-1:0]    lane_idx,
   output logic [LANES-1:0] rest
);
   always_comb begin
      lane_idx = '0;
      for (int i = 0; i < LANES; i++) begin
         if (pend[i]) lane_idx = LW'(i);
      end
      rest = pend;
      rest[lane_idx] = 1'b0;
   end
endmodule

// File: rtl/mbic_lane_merge.sv
module mbic_lane_merge #(
   parameter int REG_W  = 64,
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int FIELD_W = LANES * BYTE_W
) (
   input  logic [REG_W-1:0]  reg_v,
   input  logic              upper,
   input  logic [LW-1:0]     lane_idx,
   input  logic [BYTE_W-1:0] new_byte,
   output logic [BYTE_W-1:0] lane_byte,
   output logic [REG_W-1:0]  merged
);
   logic [REG_W-1:0]  lane_sel [LANES];
   logic [BYTE_W-1:0] lane_val [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LO_POS = g * BYTE_W;
      localparam int HI_POS = FIELD_W + g * BYTE_W;
      always_comb begin
         lane_sel[g] = reg_v;
         if (upper) begin
            lane_val[g] = reg_v[HI_POS +: BYTE_W];
            lane_sel[g][HI_POS +: BYTE_W] = new_byte;
         end else begin
            lane_val[g] = reg_v[LO_POS +: BYTE_W];
            lane_sel[g][LO_POS +: BYTE_W] = new_byte;
         end
      end
   end

   always_comb begin
      lane_byte = lane_val[0];
      merged    = lane_sel[0];
      for (int i = 0; i < LANES; i++) begin
         if (lane_idx == LW'(i)) begin
            lane_byte = lane_val[i];
            merged    = lane_sel[i];
         end
      end
   end
endmodule

// File: rtl/mbic_cc_step.sv
module mbic_cc_step
   import mbic_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  mbic_op_e          op,
   input  logic              first,
   input  logic [1:0]        cc_cur,
   input  logic [BYTE_W-1:0] reg_byte,
   input  logic [BYTE_W-1:0] mem_byte,
   output logic [1:0]        cc_next,
   output logic              stop
);
   always_comb begin
      cc_next = cc_cur;
      stop    = 1'b0;
      unique case (op)
         OP_INSERT: begin
            if (first) begin
               if (mem_byte[BYTE_W-1])   cc_next = CC_ONE;
               else if (mem_byte != '0) cc_next = CC_TWO;
               else                     cc_next = CC_ZERO;
            end else if (cc_cur == CC_ZERO && mem_byte != '0) begin
               cc_next = CC_TWO;
            end
         end
         OP_COMPARE: begin
            if (reg_byte < mem_byte) begin
               cc_next = CC_ONE;
               stop    = 1'b1;
            end else if (reg_byte > mem_byte) begin
               cc_next = CC_TWO;
               stop    = 1'b1;
            end
         end
         default: begin
            cc_next = cc_cur;
         end
      endcase
   end
endmodule

// File: rtl/mbic_unit.sv
module mbic_unit
   import mbic_pkg::*;
#(
   parameter int REG_W        = 64,
   parameter int LANES        = 4,
   parameter int BYTE_W       = 8,
   parameter int ADDR_W       = 16,
   parameter bit HIGH_HALF_EN = 1'b1,
   localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int FIELD_W = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic              high_half,
   input  logic [LANES-1:0]  mask,
   input  logic [REG_W-1:0]  reg_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [REG_W-1:0]  reg_out,
   output logic [1:0]        cc,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_valid
);
   if (HIGH_HALF_EN && REG_W < 2 * FIELD_W) begin : g_chk_hi
      $error("register too narrow for the high-half lanes");
   end
   if (REG_W < FIELD_W) begin : g_chk_lo
      $error("register narrower than the lane field");
   end
   if (BYTE_W < 1 || LANES < 1) begin : g_chk_sz
      $error("lane geometry must be positive");
   end

   mbic_state_e       state_q;
   mbic_op_e          op_q;
   logic              hh_q;
   logic [LANES-1:0]  pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [REG_W-1:0]  reg_q;
   logic [1:0]        cc_q;
   logic              first_q;

   logic [LW-1:0]     lane_idx;
   logic [LANES-1:0]  rest;
   logic [BYTE_W-1:0] reg_byte;
   logic [REG_W-1:0]  merged;
   logic [1:0]        cc_next;
   logic              stop;
   logic              upper_sel;
   logic              accept;
   logic              step;

   if (HIGH_HALF_EN) begin : g_hi
      assign upper_sel = hh_q;
   end else begin : g_lo
      assign upper_sel = 1'b0;
   end

   mbic_lane_scan #(.LANES(LANES)) u_scan (
      .pend     (pend_q),
      .lane_idx (lane_idx),
      .rest     (rest)
   );

   mbic_lane_merge #(.REG_W(REG_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
      .reg_v     (reg_q),
      .upper     (upper_sel),
      .lane_idx  (lane_idx),
      .new_byte  (mem_rdata),
      .lane_byte (reg_byte),
      .merged    (merged)
   );

   mbic_cc_step #(.BYTE_W(BYTE_W)) u_cc (
      .op       (op_q),
      .first    (first_q),
      .cc_cur   (cc_q),
      .reg_byte (reg_byte),
      .mem_byte (mem_rdata),
      .cc_next  (cc_next),
      .stop     (stop)
   );

   assign accept = (state_q == ST_IDLE) && start && (op != 2'(OP_RSVD));
   assign step   = (state_q == ST_ACC) && mem_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_INSERT;
         hh_q    <= 1'b0;
         pend_q  <= '0;
         addr_q  <= '0;
         reg_q   <= '0;
         cc_q    <= CC_ZERO;
         first_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q    <= mbic_op_e'(op);
                  hh_q    <= high_half;
                  pend_q  <= mask;
                  addr_q  <= addr_in;
                  reg_q   <= reg_in;
                  cc_q    <= CC_ZERO;
                  first_q <= 1'b1;
                  state_q <= (mask == '0) ? ST_DONE : ST_ACC;
               end
            end
            ST_ACC: begin
               if (step) begin
                  if (op_q == OP_INSERT) reg_q <= merged;
                  cc_q    <= cc_next;
                  first_q <= 1'b0;
                  pend_q  <= rest;
                  addr_q  <= addr_q + 1'b1;
                  if (stop || rest == '0) state_q <= ST_DONE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign reg_out   = reg_q;
   assign cc        = cc_q;
   assign done      = (state_q == ST_DONE);
   assign mem_req   = (state_q == ST_ACC);
   assign mem_we    = (op_q == OP_STORE);
   assign mem_addr  = addr_q;
   assign mem_wdata = reg_byte;

   // R8: done is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: a waiting request keeps address, direction and data steady
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R2: the next request uses the following address
   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid) |=> (!mem_req || mem_addr == $past(mem_addr) + 1'b1));

   // R6: store never alters the register
   a_r6_store_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> $stable(reg_out));

   // R9: start while busy does not reload the register
   a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid && start) |=> $stable(reg_out));

   // R10: nothing is requested and nothing completes right after reset
   a_r10_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!done && !mem_req));
endmodule

// File: tb/tb_mbic_unit.sv
`timescale 1ns/1ps
module tb_mbic_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        high_half = 1'b0;
   logic [3:0]  mask = 4'd0;
   logic [63:0] reg_in = '0;
   logic [15:0] addr_in = '0;
   logic [63:0] reg_out;
   logic [1:0]  cc;
   logic        done;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_valid = 1'b0;

   int checks = 0;
   int errors = 0;
   int nreq = 0;
   logic [7:0] m   [64];
   logic [7:0] ref_m [64];

   always #2.5 clk = ~clk;

   mbic_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .high_half(high_half),
      .mask(mask), .reg_in(reg_in), .addr_in(addr_in), .reg_out(reg_out),
      .cc(cc), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_valid(mem_valid)
   );

   always @(posedge clk) begin
      if (mem_req && !mem_valid) begin
         mem_valid <= 1'b1;
         nreq <= nreq + 1;
         mem_rdata <= m[mem_addr[5:0]];
         if (mem_we) m[mem_addr[5:0]] <= mem_wdata;
      end else begin
         mem_valid <= 1'b0;
      end
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] o, input logic hh, input logic [3:0] mk,
                      input logic [63:0] rv, input logic [7:0] a0, input bit poke);
      logic [63:0] e_reg;
      logic [1:0]  e_cc;
      int n, ad, base, cyc;
      bit first, stp;
      logic [7:0] rb, mb;
      e_reg = rv; e_cc = 2'd0; n = 0; ad = a0; first = 1; stp = 0;
      base = hh ? 32 : 0;
      for (int k = 0; k < 64; k++) ref_m[k] = m[k];
      for (int i = 3; i >= 0; i--) begin
         if (mk[i] && !stp) begin
            n++;
            rb = rv[base + i*8 +: 8];
            mb = ref_m[ad];
            case (o)
               2'd0: begin
                  e_reg[base + i*8 +: 8] = mb;
                  if (first) e_cc = mb[7] ? 2'd1 : (mb != 0 ? 2'd2 : 2'd0);
                  else if (e_cc == 2'd0 && mb != 0) e_cc = 2'd2;
               end
               2'd1: begin
                  if (rb < mb) begin e_cc = 2'd1; stp = 1; end
                  else if (rb > mb) begin e_cc = 2'd2; stp = 1; end
               end
               default: ref_m[ad] = rb;
            endcase
            first = 0;
            ad++;
         end
      end
      nreq = 0;
      @(negedge clk);
      start = 1; op = o; high_half = hh; mask = mk; reg_in = rv; addr_in = 16'(a0);
      @(negedge clk);
      start = 0;
      cyc = 1;
      if (poke) begin
         start = 1; op = 2'd0; mask = 4'hF; reg_in = ~rv; high_half = ~hh; addr_in = 16'd40;
      end
      while (!done && cyc < 40) begin
         @(negedge clk);
         start = 0;
         cyc++;
      end
      start = 0;
      chk(done, "R8 done seen", 64'(done), 64'd1);
      chk(reg_out == e_reg, (hh ? "R7 R3 reg high" : "R3 R1 reg"), reg_out, e_reg);
      chk(cc == e_cc, (o == 2'd0) ? "R4 insert cc" : (o == 2'd1 ? "R5 compare cc" : "R6 store cc"),
          64'(cc), 64'(e_cc));
      chk(cyc == 2*n + 1, "R8 R2 latency", 64'(cyc), 64'(2*n+1));
      chk(nreq == n, "R2 R5 request count", 64'(nreq), 64'(n));
      if (o == 2'd2)
         for (int k = 0; k < 64; k++)
            if (m[k] !== ref_m[k]) chk(0, "R6 store memory", 64'(m[k]), 64'(ref_m[k]));
      @(negedge clk);
      chk(!done && !mem_req, "R8 R9 done single and no restart", 64'({done, mem_req}), 64'd0);
   endtask

   initial begin
      logic [63:0] rv;
      int sel;
      repeat (3) @(negedge clk);
      chk(!done && !mem_req && reg_out == 0 && cc == 0, "R10 reset state",
          {reg_out[61:0], done, mem_req}, 64'd0);
      rst_n = 1;
      @(negedge clk);
      // R9: reserved opcode is ignored
      start = 1; op = 2'd3; mask = 4'hF; reg_in = 64'h1234; addr_in = 0;
      @(negedge clk);
      start = 0;
      begin
         bit seen = 0;
         repeat (8) begin
            @(negedge clk);
            if (done || mem_req) seen = 1;
         end
         chk(!seen && reg_out == 0, "R9 reserved opcode ignored", 64'(seen), 64'd0);
      end
      for (int o = 0; o < 3; o++)
         for (int hh = 0; hh < 2; hh++)
            for (int mk = 0; mk < 16; mk++)
               for (int p = 0; p < 4; p++) begin
                  rv = 64'h8A3C_5F01_E27B_9D46 ^ ({16{4'(mk)}} << p);
                  for (int k = 0; k < 64; k++)
                     m[k] = (p == 0) ? 8'h00 : 8'(k*37 + 11 + p);
                  if (p >= 2) begin
                     sel = 0;
                     for (int i = 3; i >= 0; i--)
                        if (mk[i]) begin
                           m[8+sel] = rv[(hh ? 32 : 0) + i*8 +: 8];
                           if (p == 3 && sel == 1) m[8+sel] = m[8+sel] + ((mk[0]) ? 8'h01 : 8'hFF);
                           sel++;
                        end
                  end
                  run(2'(o), 1'(hh), 4'(mk), rv, 8'd8, (p == 1));
               end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule